// File: doc/BRIEF.md
# Width-Aware Load Data Extender

This block sits in the load return path of a 64-bit core that also runs legacy 32-bit code. The data cache delivers a full aligned 64-bit doubleword each cycle. The block uses the low address bits and an access size to pick the addressed bytes and right-align them. It then widens the result to a full register value. Byte and halfword results are sign or zero extended according to a signed/unsigned flag. A word result is sign extended when the core runs in 64-bit mode and zero extended when it runs in 32-bit compatibility mode. Misaligned accesses are flagged. A doubleword load issued in 32-bit mode is reported as an illegal instruction and returns no data.

A second, independent path is a right shifter with an operand-width control. In 32-bit width it works on the low half of the operand and extends the result from bit 31. In 64-bit width it extends from bit 63. Either shift is logical or arithmetic. Both paths are registered, so each has a latency of one cycle and its own valid output.

Top module: `load_width_extender`

## Requirements
- R1: A load result appears on the cycle after its request: `ld_valid_o` equals `ld_valid_i` of the previous clock.
- R2: Byte lanes are little-endian. Byte k of the doubleword is bits 8k+7..8k. A byte load at address a returns byte a. A halfword load returns bytes a and a+1, and a word load returns bytes a..a+3, with the lowest address in the least significant position.
- R3: For byte (size code 0) and halfword (size code 1) loads, `ld_signed_i` = 1 sign extends and 0 zero extends. `mode64_i` has no effect on these loads.
- R4: A word load (size code 2) with `mode64_i` = 1 sign extends bit 31 of the word to 64 bits, whatever the value of `ld_signed_i`.
- R5: A word load with `mode64_i` = 0 zero extends the word to 64 bits, whatever the value of `ld_signed_i`.
- R6: A doubleword load (size code 3) with `mode64_i` = 1 at address 0 returns all 64 bits unchanged.
- R7: `ld_misalign_o` is set when a halfword address is odd, a word address is not a multiple of 4, or a doubleword address is not 0. A flagged load returns data 0.
- R8: A doubleword load with `mode64_i` = 0 sets `ld_illegal_o` and returns data 0. If its address is also misaligned, both flags are set.
- R9: On a cycle when `ld_valid_o` is 0, `ld_data_o`, `ld_misalign_o` and `ld_illegal_o` are all 0.
- R10: With `sh_wide_i` = 1, the shifter shifts all 64 bits right by `sh_amt_i` (0..63). `sh_arith_i` = 1 fills with bit 63 and 0 fills with zeros.
- R11: With `sh_wide_i` = 0, the shifter uses only bits 31..0 of the operand and bits 4..0 of the amount. It shifts the 32-bit value right, filling with bit 31 when arithmetic or with zeros when logical. The 32-bit result is then sign extended (arithmetic) or zero extended (logical) to 64 bits.
- R12: A shift result appears on the cycle after its request: `sh_valid_o` equals `sh_valid_i` of the previous clock. When `sh_valid_o` is 0, `sh_data_o` is 0.
- R13: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit compatibility mode |
| ld_valid_i | input | 1 | Load request valid |
| ld_word_i | input | 64 | Aligned doubleword read from the data cache |
| ld_addr_i | input | 3 | Low address bits (byte offset within the doubleword) |
| ld_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| ld_signed_i | input | 1 | 1 = sign extend byte/halfword loads |
| sh_valid_i | input | 1 | Shift request valid |
| sh_value_i | input | 64 | Shift operand |
| sh_amt_i | input | 6 | Shift amount |
| sh_arith_i | input | 1 | 1 = arithmetic, 0 = logical |
| sh_wide_i | input | 1 | Operand width: 1 = 64-bit, 0 = 32-bit |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 64 | Extended load result |
| ld_misalign_o | output | 1 | Misaligned access flag |
| ld_illegal_o | output | 1 | Doubleword load in 32-bit mode |
| sh_valid_o | output | 1 | Shift result valid |
| sh_data_o | output | 64 | Shift result |

## Verification
The bench builds two instances from the same stimulus, both with the defaults XLEN = 64 and LANE_W = 8. One uses LOG_SHIFTER = 1, a staged shifter with one mux level per amount bit. The other uses LOG_SHIFTER = 0, a single shift operator. Every shift is checked on both instances, so both generate variants are exercised, including the amounts 0, 31, 63 and a 32-bit shift whose amount has bit 5 set. Loads cover every byte lane, every aligned halfword and word in both modes with both signedness values, and each misalignment and illegal-mode combination.

// File: rtl/lwx_pkg.sv
package lwx_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } lwx_size_e;
endpackage

// File: rtl/lwx_lane_pick.sv
module lwx_lane_pick #(
   parameter int XLEN   = 64,
   parameter int LANE_W = 8
) (
   input  logic [XLEN-1:0]                    word_i,
   input  logic [$clog2(XLEN/LANE_W)-1:0]     addr_i,
   input  logic [1:0]                         size_i,
   output logic [XLEN-1:0]                    raw_o,
   output logic                               misalign_o
);
   localparam int NLANE = XLEN / LANE_W;
   localparam int AW    = $clog2(NLANE);
   localparam int LSH   = $clog2(LANE_W);
   localparam int SHW   = $clog2(XLEN);

   if (AW + LSH != SHW) begin : g_bad_geom
      $error("lwx_lane_pick: lane geometry does not tile the word");
   end

   logic [AW-1:0]  mask;
   logic [AW-1:0]  base;
   logic [SHW-1:0] bit_off;

   always_comb begin
      mask       = AW'((1 << size_i) - 1);
      misalign_o = |(addr_i & mask);
      base       = addr_i & ~mask;
      bit_off    = {base, {LSH{1'b0}}};
      raw_o      = word_i >> bit_off;
   end
endmodule

// File: rtl/lwx_extend.sv
module lwx_extend
   import lwx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] raw_i,
   input  logic [1:0]      size_i,
   input  logic            signed_i,
   input  logic            mode64_i,
   output logic [XLEN-1:0] value_o,
   output logic            illegal_o
);
   localparam int NARROW = XLEN / 2;

   logic fill;

   always_comb begin
      fill      = 1'b0;
      illegal_o = 1'b0;
      value_o   = raw_i;
      unique case (lwx_size_e'(size_i))
         SZ_BYTE: begin
            fill    = signed_i & raw_i[7];
            value_o = {{(XLEN-8){fill}}, raw_i[7:0]};
         end
         SZ_HALF: begin
            fill    = signed_i & raw_i[15];
            value_o = {{(XLEN-16){fill}}, raw_i[15:0]};
         end
         SZ_WORD: begin
            // Mode, not the signed flag, picks the extension of a word.
            fill    = mode64_i & raw_i[NARROW-1];
            value_o = {{(XLEN-NARROW){fill}}, raw_i[NARROW-1:0]};
         end
         SZ_DBL: begin
            value_o   = raw_i;
            illegal_o = ~mode64_i;
         end
         default: value_o = raw_i;
      endcase
   end
endmodule

// File: rtl/lwx_shift_right.sv
module lwx_shift_right #(
   parameter int XLEN        = 64,
   parameter bit LOG_SHIFTER = 1'b1
) (
   input  logic [XLEN-1:0]         value_i,
   input  logic [$clog2(XLEN)-1:0] amt_i,
   input  logic                    arith_i,
   input  logic                    wide_i,
   output logic [XLEN-1:0]         result_o
);
   localparam int SHW    = $clog2(XLEN);
   localparam int NARROW = XLEN / 2;

   logic [XLEN-1:0] opnd;
   logic [SHW-1:0]  eff_amt;
   logic            fill;

   // Narrow width: pre-extend the low half, then one full-width shift
   // leaves the upper half already extended from bit NARROW-1.
   always_comb begin
      if (wide_i) begin
         opnd    = value_i;
         eff_amt = amt_i;
      end else begin
         opnd    = {{NARROW{arith_i & value_i[NARROW-1]}}, value_i[NARROW-1:0]};
         eff_amt = {1'b0, amt_i[SHW-2:0]};
      end
      fill = arith_i & opnd[XLEN-1];
   end

   if (LOG_SHIFTER) begin : g_log
      logic [XLEN-1:0] stg [SHW+1];
      assign stg[0] = opnd;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int D = 1 << k;
         assign stg[k+1] = eff_amt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
      end
      assign result_o = stg[SHW];
   end else begin : g_flat
      assign result_o = fill ? ~((~opnd) >> eff_amt) : (opnd >> eff_amt);
   end
endmodule

// File: rtl/load_width_extender.sv
module load_width_extender #(
   parameter int XLEN        = 64,
   parameter int LANE_W      = 8,
   parameter bit LOG_SHIFTER = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           mode64_i,
   input  logic                           ld_valid_i,
   input  logic [XLEN-1:0]                ld_word_i,
   input  logic [$clog2(XLEN/LANE_W)-1:0] ld_addr_i,
   input  logic [1:0]                     ld_size_i,
   input  logic                           ld_signed_i,
   input  logic                           sh_valid_i,
   input  logic [XLEN-1:0]                sh_value_i,
   input  logic [$clog2(XLEN)-1:0]        sh_amt_i,
   input  logic                           sh_arith_i,
   input  logic                           sh_wide_i,
   output logic                           ld_valid_o,
   output logic [XLEN-1:0]                ld_data_o,
   output logic                           ld_misalign_o,
   output logic                           ld_illegal_o,
   output logic                           sh_valid_o,
   output logic [XLEN-1:0]                sh_data_o
);
   localparam int NARROW = XLEN / 2;

   if (XLEN != 64 || LANE_W != 8) begin : g_bad_param
      $error("load_width_extender: size codes assume 64-bit words of 8-bit lanes");
   end

   logic [XLEN-1:0] raw;
   logic            mis;
   logic [XLEN-1:0] ext_val;
   logic            ill;
   logic [XLEN-1:0] sh_res;
   logic            fault;

   lwx_lane_pick #(.XLEN(XLEN), .LANE_W(LANE_W)) u_pick (
      .word_i     (ld_word_i),
      .addr_i     (ld_addr_i),
      .size_i     (ld_size_i),
      .raw_o      (raw),
      .misalign_o (mis)
   );

   lwx_extend #(.XLEN(XLEN)) u_ext (
      .raw_i     (raw),
      .size_i    (ld_size_i),
      .signed_i  (ld_signed_i),
      .mode64_i  (mode64_i),
      .value_o   (ext_val),
      .illegal_o (ill)
   );

   lwx_shift_right #(.XLEN(XLEN), .LOG_SHIFTER(LOG_SHIFTER)) u_shr (
      .value_i  (sh_value_i),
      .amt_i    (sh_amt_i),
      .arith_i  (sh_arith_i),
      .wide_i   (sh_wide_i),
      .result_o (sh_res)
   );

   assign fault = mis | ill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid_o    <= 1'b0;
         ld_data_o     <= '0;
         ld_misalign_o <= 1'b0;
         ld_illegal_o  <= 1'b0;
         sh_valid_o    <= 1'b0;
         sh_data_o     <= '0;
      end else begin
         ld_valid_o    <= ld_valid_i;
         ld_data_o     <= (ld_valid_i && !fault) ? ext_val : '0;
         ld_misalign_o <= ld_valid_i & mis;
         ld_illegal_o  <= ld_valid_i & ill;
         sh_valid_o    <= sh_valid_i;
         sh_data_o     <= sh_valid_i ? sh_res : '0;
      end
   end

   p_ld_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_o == $past(ld_valid_i));

   p_word32_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_o && $past(ld_size_i) == 2'd2 && !$past(mode64_i))
         |-> ld_data_o[XLEN-1:NARROW] == '0);

   p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_o && (ld_misalign_o || ld_illegal_o)) |-> ld_data_o == '0);

   p_illegal_dbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_o |-> (ld_illegal_o == ($past(ld_size_i) == 2'd3 && !$past(mode64_i))));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid_o |-> (!ld_misalign_o && !ld_illegal_o && ld_data_o == '0));

   p_narrow_logical_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_valid_o && !$past(sh_wide_i) && !$past(sh_arith_i))
         |-> sh_data_o[XLEN-1:NARROW] == '0);

   p_sh_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sh_valid_o == $past(sh_valid_i));
endmodule

// File: tb/load_width_extender_bench.sv
module load_width_extender_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64_i = 1'b1;
   logic        ld_valid_i = 1'b0;
   logic [63:0] ld_word_i = '0;
   logic [2:0]  ld_addr_i = '0;
   logic [1:0]  ld_size_i = '0;
   logic        ld_signed_i = 1'b0;
   logic        sh_valid_i = 1'b0;
   logic [63:0] sh_value_i = '0;
   logic [5:0]  sh_amt_i = '0;
   logic        sh_arith_i = 1'b0;
   logic        sh_wide_i = 1'b0;

   logic        ld_valid_o, ld_misalign_o, ld_illegal_o, sh_valid_o;
   logic [63:0] ld_data_o, sh_data_o;
   logic        f_ld_valid_o, f_ld_misalign_o, f_ld_illegal_o, f_sh_valid_o;
   logic [63:0] f_ld_data_o, f_sh_data_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   load_width_extender u_load_width_extender (
      .clk(clk), .rst_n(rst_n), .mode64_i(mode64_i),
      .ld_valid_i(ld_valid_i), .ld_word_i(ld_word_i), .ld_addr_i(ld_addr_i),
      .ld_size_i(ld_size_i), .ld_signed_i(ld_signed_i),
      .sh_valid_i(sh_valid_i), .sh_value_i(sh_value_i), .sh_amt_i(sh_amt_i),
      .sh_arith_i(sh_arith_i), .sh_wide_i(sh_wide_i),
      .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o),
      .ld_misalign_o(ld_misalign_o), .ld_illegal_o(ld_illegal_o),
      .sh_valid_o(sh_valid_o), .sh_data_o(sh_data_o)
   );

   load_width_extender #(.LOG_SHIFTER(1'b0)) u_load_width_extender_flat (
      .clk(clk), .rst_n(rst_n), .mode64_i(mode64_i),
      .ld_valid_i(ld_valid_i), .ld_word_i(ld_word_i), .ld_addr_i(ld_addr_i),
      .ld_size_i(ld_size_i), .ld_signed_i(ld_signed_i),
      .sh_valid_i(sh_valid_i), .sh_value_i(sh_value_i), .sh_amt_i(sh_amt_i),
      .sh_arith_i(sh_arith_i), .sh_wide_i(sh_wide_i),
      .ld_valid_o(f_ld_valid_o), .ld_data_o(f_ld_data_o),
      .ld_misalign_o(f_ld_misalign_o), .ld_illegal_o(f_ld_illegal_o),
      .sh_valid_o(f_sh_valid_o), .sh_data_o(f_sh_data_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mdl_load(input logic [63:0] d, input int a,
                                            input int s, input logic sg,
                                            input logic m64);
      int nb = 1 << s;
      logic [63:0] v = '0;
      logic fl = 1'b0;
      if ((a % nb) != 0) return '0;
      if (s == 3 && !m64) return '0;
      for (int i = 0; i < nb; i++) v[8*i +: 8] = d[8*(a+i) +: 8];
      if (s < 2) fl = sg & v[8*nb-1];
      else if (s == 2) fl = m64 & v[31];
      for (int i = 8*nb; i < 64; i++) v[i] = fl;
      return v;
   endfunction

   function automatic logic [63:0] mdl_shift(input logic [63:0] v, input int amt,
                                             input logic ar, input logic wd);
      logic [31:0] r32;
      if (wd) begin
         if (ar) return $signed(v) >>> amt;
         return v >> amt;
      end
      if (ar) begin
         r32 = $signed(v[31:0]) >>> (amt % 32);
         return {{32{r32[31]}}, r32};
      end
      r32 = v[31:0] >> (amt % 32);
      return {32'h0, r32};
   endfunction

   task automatic do_load(input string req, input logic [63:0] d, input int a,
                          input int s, input logic sg, input logic m64);
      logic [63:0] e;
      int nb = 1 << s;
      e = mdl_load(d, a, s, sg, m64);
      @(negedge clk);
      ld_valid_i = 1'b1; ld_word_i = d; ld_addr_i = 3'(a);
      ld_size_i = 2'(s); ld_signed_i = sg; mode64_i = m64;
      @(negedge clk);
      ld_valid_i = 1'b0;
      chk("R1", "ld_valid_o", 64'(ld_valid_o), 64'd1);
      chk(req, "ld_data_o", ld_data_o, e);
      chk("R7", "ld_misalign_o", 64'(ld_misalign_o), 64'((a % nb) != 0));
      chk("R8", "ld_illegal_o", 64'(ld_illegal_o), 64'(s == 3 && !m64));
   endtask

   task automatic do_shift(input string req, input logic [63:0] v, input int amt,
                           input logic ar, input logic wd);
      logic [63:0] e;
      e = mdl_shift(v, amt, ar, wd);
      @(negedge clk);
      sh_valid_i = 1'b1; sh_value_i = v; sh_amt_i = 6'(amt);
      sh_arith_i = ar; sh_wide_i = wd;
      @(negedge clk);
      sh_valid_i = 1'b0;
      chk("R12", "sh_valid_o", 64'(sh_valid_o), 64'd1);
      chk(req, "sh_data_o log", sh_data_o, e);
      chk(req, "sh_data_o flat", f_sh_data_o, e);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R13", "ld_valid_o", 64'(ld_valid_o), 64'd0);
      chk("R13", "ld_data_o", ld_data_o, 64'd0);
      chk("R13", "flags", {62'd0, ld_misalign_o, ld_illegal_o}, 64'd0);
      chk("R13", "sh_valid_o", 64'(sh_valid_o), 64'd0);
      chk("R13", "sh_data_o", sh_data_o, 64'd0);
   endtask

   task automatic t_bytes;
      for (int a = 0; a < 8; a++) begin
         do_load("R2 R3 byte", 64'h8091_A2B3_74E5_56C7, a, 0, 1'b1, 1'b1);
         do_load("R2 R3 byte", 64'h8091_A2B3_74E5_56C7, a, 0, 1'b0, 1'b1);
         do_load("R3 byte mode32", 64'h8091_A2B3_74E5_56C7, a, 0, 1'b1, 1'b0);
      end
   endtask

   task automatic t_halves;
      for (int a = 0; a < 8; a += 2) begin
         for (int m = 0; m < 2; m++) begin
            do_load("R2 R3 half", 64'h7F01_8002_FFFE_0180, a, 1, 1'b1, m[0]);
            do_load("R2 R3 half", 64'h7F01_8002_FFFE_0180, a, 1, 1'b0, m[0]);
         end
      end
   endtask

   task automatic t_words;
      for (int a = 0; a < 8; a += 4) begin
         do_load("R4 word signed", 64'h8765_4321_F000_000F, a, 2, 1'b1, 1'b1);
         do_load("R4 word unsigned flag", 64'h8765_4321_F000_000F, a, 2, 1'b0, 1'b1);
         do_load("R5 word signed flag", 64'h8765_4321_F000_000F, a, 2, 1'b1, 1'b0);
         do_load("R5 word unsigned", 64'h8765_4321_F000_000F, a, 2, 1'b0, 1'b0);
      end
   endtask

   task automatic t_dword;
      do_load("R6 dword", 64'hDEAD_BEEF_0123_4567, 0, 3, 1'b0, 1'b1);
      do_load("R6 dword", 64'h8000_0000_0000_0001, 0, 3, 1'b1, 1'b1);
   endtask

   task automatic t_misalign;
      do_load("R7 half odd", 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1'b1, 1'b1);
      do_load("R7 half odd", 64'hFFFF_FFFF_FFFF_FFFF, 7, 1, 1'b0, 1'b1);
      do_load("R7 word off2", 64'hFFFF_FFFF_FFFF_FFFF, 2, 2, 1'b1, 1'b1);
      do_load("R7 word off5", 64'hFFFF_FFFF_FFFF_FFFF, 5, 2, 1'b1, 1'b0);
      do_load("R7 dword off4", 64'hFFFF_FFFF_FFFF_FFFF, 4, 3, 1'b1, 1'b1);
   endtask

   task automatic t_illegal;
      do_load("R8 dword mode32", 64'h1234_5678_9ABC_DEF0, 0, 3, 1'b0, 1'b0);
      do_load("R8 dword mode32 off3", 64'h1234_5678_9ABC_DEF0, 3, 3, 1'b1, 1'b0);
   endtask

   task automatic t_idle;
      do_load("R7 prior", 64'hFFFF_FFFF_FFFF_FFFF, 1, 2, 1'b1, 1'b0);
      @(negedge clk);
      chk("R9", "ld_valid_o idle", 64'(ld_valid_o), 64'd0);
      chk("R9", "ld_data_o idle", ld_data_o, 64'd0);
      chk("R9", "flags idle", {62'd0, ld_misalign_o, ld_illegal_o}, 64'd0);
      chk("R12", "sh_data_o idle", sh_data_o, 64'd0);
   endtask

   task automatic t_shift64;
      int amts[5] = '{0, 1, 13, 32, 63};
      foreach (amts[i]) begin
         do_shift("R10 wide arith", 64'h8F00_0000_0000_00F1, amts[i], 1'b1, 1'b1);
         do_shift("R10 wide logic", 64'h8F00_0000_0000_00F1, amts[i], 1'b0, 1'b1);
         do_shift("R10 wide arith pos", 64'h7F00_1234_0000_00F1, amts[i], 1'b1, 1'b1);
      end
   endtask

   task automatic t_shift32;
      int amts[5] = '{0, 1, 7, 31, 33};
      foreach (amts[i]) begin
         do_shift("R11 narrow arith", 64'h5555_AAAA_8000_1234, amts[i], 1'b1, 1'b0);
         do_shift("R11 narrow logic", 64'h5555_AAAA_8000_1234, amts[i], 1'b0, 1'b0);
         do_shift("R11 narrow arith pos", 64'hFFFF_FFFF_7000_1234, amts[i], 1'b1, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_bytes();
      t_halves();
      t_words();
      t_dword();
      t_misalign();
      t_illegal();
      t_idle();
      t_shift64();
      t_shift32();
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule